// File: doc/BRIEF.md
# Overlapping-Window Approximate Adder

This block adds two WIDTH-bit operands without running the carry the full width. The operands are cut into K-bit slices, and a 2K-bit sub-adder is placed at every slice boundary. Each sub-adder assumes a carry-in of zero and keeps only the upper half of its sum. The lowest sub-adder keeps all 2K of its bits. So every sum bit sees carries from at most 2K-1 lower bit positions. The longest carry path is 2K bits wide whatever WIDTH is. A larger K gives a slower but more often exact result.

Beside the sum, the block gives one flag per window. A flag is set when the lower half of that window propagates on every bit and the neighbouring window below produces a carry at the window's base. In that case the carry that was dropped would have changed the window's output. The flags are built only from propagate bits and the local carries that the sub-adders already compute. Correcting the sum is left to the user.

Operands enter on a valid/ready handshake and the result leaves from one output register on a second valid/ready handshake. A new operand pair is accepted when the register is empty or is being emptied in the same cycle. While the consumer holds back `out_ready`, the result stays frozen and `in_ready` is low.

Top module: `aca_adder`

## Requirements
- R1: After reset, and until the first operand pair is accepted, `out_valid` is 0.
- R2: `in_ready` is 1 exactly when `out_valid` is 0 or `out_ready` is 1. An operand pair offered with `in_valid` and `in_ready` both high at a rising edge appears at the outputs with `out_valid` high just after that edge.
- R3: While `out_valid` is 1 and `out_ready` is 0, `out_sum`, `out_carry` and `out_err` do not change and `out_valid` stays 1. An operand pair offered during such a stall is not taken.
- R4: Bits [2K-1:0] of `out_sum` equal the exact sum of the operands' bits [2K-1:0], with the carry out of bit 2K-1 dropped.
- R5: For each window i from 1 to WIDTH/K-2, `out_sum` bits [iK+2K-1 : iK+K] are the upper K bits of the 2K-bit sum of operand bits [iK+2K-1 : iK] taken with a carry-in of zero.
- R6: `out_carry` is the carry out of the top window, meaning operand bits [WIDTH-1 : WIDTH-2K] added with a carry-in of zero.
- R7: `out_err` bit 0 is always 0. For i ≥ 1, `out_err` bit i is 1 exactly when every bit of a XOR b in [iK+K-1 : iK] is 1 and operand bits [iK-1 : iK-K] added with a carry-in of zero produce a carry out.
- R8: When any `out_err` bit is 1, {`out_carry`, `out_sum`} differs from the exact (WIDTH+1)-bit sum of the operands.
- R9: When {`out_carry`, `out_sum`} differs from the exact (WIDTH+1)-bit sum of the operands, at least one `out_err` bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand pair offered |
| in_ready | output | 1 | Block can take an operand pair this cycle |
| in_a | input | WIDTH | First operand |
| in_b | input | WIDTH | Second operand |
| out_valid | output | 1 | Result register holds a result |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_sum | output | WIDTH | Approximate sum |
| out_carry | output | 1 | Carry out of the top window |
| out_err | output | WIDTH/K-1 | Per-window flag for a dropped carry, bit i for window i |

## Verification
On every cycle the assertions check the following:
- `out_valid` is low right after reset.
- Every accepted pair produces a valid result.
- Stalled results are held.
- The base flag stays low.
- The low 2K bits are always exact.
- The flags agree exactly with the cases where the result differs from an exact sum of the captured operands.

The per-window slicing of the sum, the carry out and the precise flag pattern can only be shown by the bench's scenarios. These include carries that ripple through several windows, all-ones operands, sign-bit overflow and random operand streams with random back-pressure. In each case the bench compares the outputs against a behavioural window model.

// File: rtl/aca_pkg.sv
package aca_pkg;

  // Number of overlapping sub-adder windows for a given width and slice size.
  function automatic int win_count(input int width, input int k);
    return width / k - 1;
  endfunction

endpackage

// File: rtl/aca_window.sv
// One 2K-bit sub-adder with a zero carry-in. It also exposes the carry and
// the all-propagate term of its lower K bits for the neighbour's flag.
module aca_window #(
  parameter int K = 4
) (
  input  logic [2*K-1:0] a,
  input  logic [2*K-1:0] b,
  output logic [2*K-1:0] sum,
  output logic           cout,
  output logic           low_carry,
  output logic           low_prop
);
  localparam int W2 = 2 * K;

  logic [W2:0] full_s;
  logic [K:0]  low_s;

  always_comb begin
    full_s    = {1'b0, a} + {1'b0, b};
    low_s     = {1'b0, a[K-1:0]} + {1'b0, b[K-1:0]};
    sum       = full_s[W2-1:0];
    cout      = full_s[W2];
    low_carry = low_s[K];
    low_prop  = &(a[K-1:0] ^ b[K-1:0]);
  end
endmodule

// File: rtl/aca_core.sv
// Places one window at every K-bit boundary and assembles sum, carry and flags.
module aca_core
  import aca_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int K     = 4,
  localparam int NWIN = win_count(WIDTH, K)
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] sum,
  output logic             carry,
  output logic [NWIN-1:0]  err
);
  localparam int W2 = 2 * K;

  logic [W2-1:0] win_sum [NWIN];
  logic [NWIN-1:0] win_cout;
  logic [NWIN-1:0] win_lc;
  logic [NWIN-1:0] win_lp;

  for (genvar i = 0; i < NWIN; i++) begin : g_win
    aca_window #(.K(K)) u_win (
      .a         (a[i*K +: W2]),
      .b         (b[i*K +: W2]),
      .sum       (win_sum[i]),
      .cout      (win_cout[i]),
      .low_carry (win_lc[i]),
      .low_prop  (win_lp[i])
    );

    if (i == 0) begin : g_base
      assign sum[W2-1:0] = win_sum[0];
      assign err[0]      = 1'b0;
    end else begin : g_upper
      assign sum[i*K+K +: K] = win_sum[i][W2-1:K];
      assign err[i]          = win_lp[i] & win_lc[i-1];
    end
  end

  assign carry = win_cout[NWIN-1];

  // Terms that exist in every window but are consumed only in some.
  logic unused_terms;
  assign unused_terms = ^{win_cout, win_lc[NWIN-1], win_lp[0]};
endmodule

// File: rtl/aca_out_reg.sv
// Single result register with valid/ready on both sides.
module aca_out_reg #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data
);
  logic          q_valid;
  logic [DW-1:0] q_data;

  assign in_ready  = !q_valid || out_ready;
  assign out_valid = q_valid;
  assign out_data  = q_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        q_valid <= 1'b0;
    else if (in_ready) q_valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (in_valid && in_ready) q_data <= in_data;
  end
endmodule

// File: rtl/aca_adder.sv
module aca_adder
  import aca_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int K     = 4,
  localparam int NWIN = win_count(WIDTH, K)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] in_a,
  input  logic [WIDTH-1:0] in_b,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [WIDTH-1:0] out_sum,
  output logic             out_carry,
  output logic [NWIN-1:0]  out_err
);
  localparam int DW = NWIN + 1 + WIDTH;

  logic [WIDTH-1:0] c_sum;
  logic             c_carry;
  logic [NWIN-1:0]  c_err;
  logic [DW-1:0]    q_word;

  aca_core #(.WIDTH(WIDTH), .K(K)) u_core (
    .a     (in_a),
    .b     (in_b),
    .sum   (c_sum),
    .carry (c_carry),
    .err   (c_err)
  );

  aca_out_reg #(.DW(DW)) u_oreg (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   ({c_err, c_carry, c_sum}),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (q_word)
  );

  assign {out_err, out_carry, out_sum} = q_word;
endmodule

// File: rtl/aca_adder_chk.sv
module aca_adder_chk #(
  parameter int WIDTH = 16,
  parameter int K     = 4,
  localparam int NWIN = WIDTH / K - 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [WIDTH-1:0] in_a,
  input logic [WIDTH-1:0] in_b,
  input logic             out_valid,
  input logic             out_ready,
  input logic [WIDTH-1:0] out_sum,
  input logic             out_carry,
  input logic [NWIN-1:0]  out_err
);
  localparam int W2 = 2 * K;

  logic [WIDTH-1:0] cap_a, cap_b;
  logic [WIDTH:0]   exact;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_a <= '0;
      cap_b <= '0;
    end else if (in_valid && in_ready) begin
      cap_a <= in_a;
      cap_b <= in_b;
    end
  end

  assign exact = {1'b0, cap_a} + {1'b0, cap_b};

  AST_IDLE_AFTER_RESET: assert property (@(posedge clk)
    $rose(rst_n) |-> !out_valid);                                      // R1
  AST_ACCEPT_GIVES_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);                               // R2
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_sum)
      && $stable(out_carry) && $stable(out_err));                      // R3
  AST_LOW_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_sum[W2-1:0] == exact[W2-1:0]);                   // R4
  AST_BASE_FLAG_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !out_err[0]);                                        // R7
  AST_FLAG_MEANS_WRONG: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (out_err != '0) |-> {out_carry, out_sum} != exact);   // R8
  AST_WRONG_MEANS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && ({out_carry, out_sum} != exact) |-> out_err != '0);   // R9
endmodule

bind aca_adder aca_adder_chk #(.WIDTH(WIDTH), .K(K)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_a      (in_a),
  .in_b      (in_b),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_sum   (out_sum),
  .out_carry (out_carry),
  .out_err   (out_err)
);

// File: tb/test_aca_adder.sv
module test_aca_adder;
  localparam int WIDTH = 16;
  localparam int K     = 4;
  localparam int NWIN  = WIDTH / K - 1;
  localparam int CLK_PERIOD = 10;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             in_valid = 1'b0;
  logic             in_ready;
  logic [WIDTH-1:0] in_a = '0, in_b = '0;
  logic             out_valid;
  logic             out_ready = 1'b0;
  logic [WIDTH-1:0] out_sum;
  logic             out_carry;
  logic [NWIN-1:0]  out_err;

  int checks = 0;
  int errors = 0;

  // Model state: the result the register should be holding.
  bit               mv = 0;
  logic [WIDTH-1:0] ma, mb, ms;
  logic             mc;
  logic [NWIN-1:0]  me;
  bit               stalled = 0;
  logic [WIDTH-1:0] hs;
  logic             hc;
  logic [NWIN-1:0]  he;

  aca_adder #(.WIDTH(WIDTH), .K(K)) i_aca_adder (
    .clk, .rst_n, .in_valid, .in_ready, .in_a, .in_b,
    .out_valid, .out_ready, .out_sum, .out_carry, .out_err
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Behavioural window model built from R4-R7.
  task automatic approx(input logic [WIDTH-1:0] a, input logic [WIDTH-1:0] b,
                        output logic [WIDTH-1:0] s, output logic c,
                        output logic [NWIN-1:0] e);
    longint m2 = (64'd1 << (2*K)) - 1;
    longint m1 = (64'd1 << K) - 1;
    s = '0; c = 1'b0; e = '0;
    for (int i = 0; i < NWIN; i++) begin
      longint lo = i * K;
      longint wa = (longint'(a) >> lo) & m2;
      longint wb = (longint'(b) >> lo) & m2;
      longint ws = wa + wb;
      if (i == 0) begin
        for (int j = 0; j < 2*K; j++) s[j] = ws[j];
      end else begin
        for (int j = 0; j < K; j++) s[lo+K+j] = ws[K+j];
        if (((longint'(a ^ b) >> lo) & m1) == m1 &&
            ((((longint'(a) >> (lo-K)) & m1) + ((longint'(b) >> (lo-K)) & m1)) >> K) != 0)
          e[i] = 1'b1;
      end
      if (i == NWIN-1) c = ws[2*K];
    end
  endtask

  task automatic step(input bit v, input logic [WIDTH-1:0] a, input logic [WIDTH-1:0] b,
                      input bit rdy);
    logic [WIDTH:0] ex;
    @(negedge clk);
    chk(out_valid == mv, "R2 out_valid", out_valid, mv);
    if (mv) begin
      ex = {1'b0, ma} + {1'b0, mb};
      chk(out_sum[2*K-1:0] == ms[2*K-1:0], "R4 low sum", out_sum, ms);
      chk(out_sum == ms, "R5 window sum", out_sum, ms);
      chk(out_carry == mc, "R6 carry", out_carry, mc);
      chk(out_err == me, "R7 flags", out_err, me);
      if (out_err != '0) chk({out_carry, out_sum} != ex, "R8 flag with exact result", {out_carry, out_sum}, ex);
      if ({out_carry, out_sum} != ex) chk(out_err != '0, "R9 unflagged mismatch", out_err, 1);
      if (stalled)
        chk({out_err, out_carry, out_sum} == {he, hc, hs}, "R3 held result",
            {out_err, out_carry, out_sum}, {he, hc, hs});
    end
    stalled = mv && !rdy;
    hs = out_sum; hc = out_carry; he = out_err;
    in_valid = v; in_a = a; in_b = b; out_ready = rdy;
    #1;
    chk(in_ready == (!mv || rdy), "R2 in_ready", in_ready, !mv || rdy);
    if (v && (!mv || rdy)) begin
      mv = 1; ma = a; mb = b;
      approx(a, b, ms, mc, me);
    end else if (rdy) begin
      mv = 0;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [WIDTH-1:0] dir_a [10] = '{16'h0000, 16'hFFFF, 16'h0FFF, 16'h00FF, 16'hFFFF,
                                     16'h8000, 16'h1234, 16'h0F0F, 16'h7FFF, 16'hF0F0};
    logic [WIDTH-1:0] dir_b [10] = '{16'h0000, 16'h0001, 16'h0001, 16'h0001, 16'hFFFF,
                                     16'h8000, 16'h5678, 16'h00F1, 16'h0001, 16'h0F10};
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1 valid in reset", out_valid, 0);
    rst_n = 1'b1;
    step(0, '0, '0, 1);
    chk(out_valid == 1'b0, "R1 valid after reset", out_valid, 0);

    // Carry ripples, all-ones, overflow: one per cycle, consumer always ready.
    for (int i = 0; i < 10; i++) step(1, dir_a[i], dir_b[i], 1);

    // R3: stall with a new pair offered; it must be refused.
    step(1, 16'h0FF0, 16'h0010, 0);
    step(1, 16'hAAAA, 16'h5555, 0);
    step(1, 16'h1111, 16'h2222, 0);
    step(0, '0, '0, 1);
    step(0, '0, '0, 1);

    // Random stream with random back-pressure.
    for (int n = 0; n < 4000; n++)
      step(1'($urandom_range(0, 3) != 0), WIDTH'($urandom), WIDTH'($urandom),
           1'($urandom_range(0, 3) != 0));
    step(0, '0, '0, 1);
    step(0, '0, '0, 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule